// File: doc/BRIEF.md
# Stereo Serial Audio Deserializer

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a frame clock and a data line. All three are sampled in the system clock domain. Each line first passes through a short synchronizer. Data and frame-clock levels are then taken on every detected rising edge of the bit clock. The frame clock splits every frame into a left half and a right half: a high level marks the left channel and a low level marks the right channel. Within each half the bits arrive most significant first.

Two justification modes are supported, and a static input selects between them.

- **Left-justified mode:** the word starts on the first bit-clock period after a frame-clock change. Up to 24 bits are kept, and shorter words are padded with zeros at the bottom.
- **Right-justified mode:** each half is a fixed slot of 32 bit-clock periods, and the last bit of the slot is the word's least significant bit. The start of the word therefore moves with the selected word length, and earlier bits in the slot are dropped. The word is sign-extended to 24 bits.

When the right half of a frame completes, both samples are updated together and a one-cycle strobe is raised. In right-justified mode, a slot shorter than 32 periods marks the frame as bad. A bad frame raises an error pulse instead of the strobe.

Top module: `audio_deser`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low, and after it is released until the first complete frame, both sample outputs read zero and neither `sample_valid` nor `frame_err` is asserted.
- R2: In left-justified mode (`fmt_rj`=0), the bit captured on the first rising bit-clock edge after a frame-clock change becomes bit 23 of that channel's sample. Following bits fill bits 22, 21 and so on.
- R3: In left-justified mode, a half shorter than 24 bits leaves the unfilled low-order bits zero, and any bits after the 24th in a half are discarded.
- R4: In right-justified mode (`fmt_rj`=1), the sample is the last N bits received before the frame-clock change, sign-extended from bit N-1 to 24 bits. N is selected by `wlen_sel`: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24.
- R5: In right-justified mode, bits in the 32-period slot that precede the N-bit word have no effect on the sample.
- R6: Once per frame, one system cycle after the right half ends (at the next rise of the frame clock), `sample_valid` is high for exactly one cycle. Both outputs take their new values in that same cycle and hold them in every other cycle.
- R7: In right-justified mode, if either half of a frame is shorter than 32 bit periods, `frame_err` pulses for one cycle instead of `sample_valid`, and both outputs keep their previous values.
- R8: The half sent while the frame clock is high appears on `left_sample`, and the half sent while it is low appears on `right_sample`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock (asynchronous to clk) |
| frame_clk | input | 1 | Frame clock, high for left channel |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_rj | input | 1 | 0: left-justified, 1: right-justified |
| wlen_sel | input | 2 | Right-justified word length: 0=16, 1=18, 2=20, 3=24 |
| left_sample | output | 24 | Left channel sample |
| right_sample | output | 24 | Right channel sample |
| sample_valid | output | 1 | One-cycle strobe when a frame is delivered |
| frame_err | output | 1 | One-cycle pulse when a short slot spoils a frame |

## Verification
The assertions assume that the bit clock is slow enough for every high and low phase to span several system cycles, so that each rising edge is seen exactly once through the synchronizer. They also assume that the frame clock and data change only while the bit clock is low. A further assumption is that `fmt_rj` and `wlen_sel` are static for the whole stretch from one half boundary to the next.

The stimulus keeps within these limits in three ways. Each bit-clock phase lasts six system cycles. Data and frame clock are changed together with the falling edge. Mode changes are applied only after the first bit of a new left half has been processed, so the boundary that closes the previous frame is always judged under the old mode.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;

  typedef struct packed {
    logic                left;
    logic                short_slot;
    logic [SAMPLE_W-1:0] word;
  } half_t;

  // number of payload bits for a right-justified word length code
  function automatic int wlen_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // take the low bits of the slot history and sign-extend them
  function automatic logic [SAMPLE_W-1:0] rj_extract(input logic [SLOT_W-1:0] hist,
                                                     input logic [1:0] sel);
    logic [SAMPLE_W-1:0] res;
    logic                sgn;
    int                  n;
    n   = wlen_bits(sel);
    sgn = 1'b0;
    for (int j = 0; j < SAMPLE_W; j++)
      if (j == n - 1) sgn = hist[j];
    for (int i = 0; i < SAMPLE_W; i++)
      res[i] = (i < n) ? hist[i] : sgn;
    return res;
  endfunction

endpackage

// File: rtl/aud_edge_sync.sv
module aud_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  input  logic frame_clk,
  input  logic ser_data,
  output logic bit_stb,
  output logic ws_bit,
  output logic sd_bit
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] bck_q, ws_q, sd_q;
  logic         bck_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_q    <= '0;
      ws_q     <= '0;
      sd_q     <= '0;
      bck_last <= 1'b0;
    end else begin
      bck_q    <= {bck_q[TOP-1:0], bit_clk};
      ws_q     <= {ws_q[TOP-1:0], frame_clk};
      sd_q     <= {sd_q[TOP-1:0], ser_data};
      bck_last <= bck_q[TOP];
    end
  end

  assign bit_stb = bck_q[TOP] & ~bck_last;
  assign ws_bit  = ws_q[TOP];
  assign sd_bit  = sd_q[TOP];

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R2

endmodule

// File: rtl/aud_half_capture.sv
module aud_half_capture
  import aud_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       ws_bit,
  input  logic       sd_bit,
  input  logic       fmt_rj,
  input  logic [1:0] wlen_sel,
  output logic       half_done,
  output half_t      half
);

  localparam int CNT_W              = $clog2(2 * SLOT_W) + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CSLOT = CNT_W'(SLOT_W);
  localparam logic [CNT_W-1:0] CSAMP = CNT_W'(SAMPLE_W);

  logic                have_prev, ws_prev, started;
  logic [CNT_W-1:0]    cnt;
  logic [SLOT_W-1:0]   hist;
  logic [SAMPLE_W-1:0] lj_acc, lj_next;
  logic                boundary;

  assign boundary  = bit_stb & have_prev & (ws_bit != ws_prev);
  assign half_done = boundary & started;

  // place the incoming bit at its MSB-first position
  always_comb begin
    lj_next = lj_acc;
    if (cnt < CSAMP)
      for (int i = 0; i < SAMPLE_W; i++)
        if (int'(cnt) == SAMPLE_W - 1 - i) lj_next[i] = sd_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      ws_prev   <= 1'b0;
      started   <= 1'b0;
      cnt       <= '0;
      hist      <= '0;
      lj_acc    <= '0;
    end else if (bit_stb) begin
      have_prev <= 1'b1;
      ws_prev   <= ws_bit;
      if (boundary) begin
        started <= 1'b1;
        cnt     <= CNT_W'(1);
        hist    <= {{(SLOT_W-1){1'b0}}, sd_bit};
        lj_acc  <= {sd_bit, {(SAMPLE_W-1){1'b0}}};
      end else begin
        hist    <= {hist[SLOT_W-2:0], sd_bit};
        if (cnt != CMAX) cnt <= cnt + CNT_W'(1);
        lj_acc  <= lj_next;
      end
    end
  end

  assign half.left       = ws_prev;
  assign half.short_slot = fmt_rj & (cnt < CSLOT);
  assign half.word       = fmt_rj ? rj_extract(hist, wlen_sel) : lj_acc;

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !boundary && cnt == CMAX) |=> cnt == CMAX); // R3

  AST_NEW_HALF_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !fmt_rj) |=> lj_acc[SAMPLE_W-1] == $past(sd_bit)); // R2

endmodule

// File: rtl/aud_frame_out.sv
module aud_frame_out
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_done,
  input  half_t               half,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid,
  output logic                frame_err
);

  logic [SAMPLE_W-1:0] pend_word;
  logic                pend_bad, left_seen;
  logic                frame_close, frame_bad;

  assign frame_close = half_done & ~half.left & left_seen;
  assign frame_bad   = pend_bad | half.short_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_word    <= '0;
      pend_bad     <= 1'b0;
      left_seen    <= 1'b0;
      left_sample  <= '0;
      right_sample <= '0;
      sample_valid <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      frame_err    <= 1'b0;
      if (half_done && half.left) begin
        pend_word <= half.word;
        pend_bad  <= half.short_slot;
        left_seen <= 1'b1;
      end else if (frame_close) begin
        left_seen <= 1'b0;
        if (frame_bad) begin
          frame_err <= 1'b1;
        end else begin
          left_sample  <= pend_word;
          right_sample <= half.word;
          sample_valid <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(left_sample) && $stable(right_sample))); // R6

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && frame_err)); // R7

  AST_ERR_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(half_done && !half.left)); // R7

endmodule

// File: rtl/audio_deser.sv
module audio_deser
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic                fmt_rj,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid,
  output logic                frame_err
);

  logic  bit_stb, ws_bit, sd_bit;
  logic  half_done;
  half_t half;

  aud_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_clk   (bit_clk),
    .frame_clk (frame_clk),
    .ser_data  (ser_data),
    .bit_stb   (bit_stb),
    .ws_bit    (ws_bit),
    .sd_bit    (sd_bit)
  );

  aud_half_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .ws_bit    (ws_bit),
    .sd_bit    (sd_bit),
    .fmt_rj    (fmt_rj),
    .wlen_sel  (wlen_sel),
    .half_done (half_done),
    .half      (half)
  );

  aud_frame_out u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_done    (half_done),
    .half         (half),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid),
    .frame_err    (frame_err)
  );

  AST_RJ16_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && fmt_rj && wlen_sel == 2'd0) |->
      right_sample[SAMPLE_W-1:16] == {(SAMPLE_W-16){right_sample[15]}}); // R4

  AST_ERR_RJ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> fmt_rj); // R7

endmodule

// File: tb/test_audio_deser.sv
`timescale 1ns/1ps
module test_audio_deser;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bit_clk = 1'b0, frame_clk = 1'b0, ser_data = 1'b0;
  logic        fmt_rj = 1'b0;
  logic [1:0]  wlen_sel = 2'd0;
  logic [23:0] left_sample, right_sample;
  logic        sample_valid, frame_err;

  always #4 clk = ~clk;

  audio_deser i_audio_deser (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .ser_data(ser_data), .fmt_rj(fmt_rj), .wlen_sel(wlen_sel),
    .left_sample(left_sample), .right_sample(right_sample),
    .sample_valid(sample_valid), .frame_err(frame_err)
  );

  typedef struct packed { logic err; logic [23:0] l; logic [23:0] r; } exp_t;
  exp_t exp_q[$];

  int   n_checks = 0, n_fail = 0;
  logic pend_mode = 1'b0, nxt_rj = 1'b0, cur_rj = 1'b0;
  logic [1:0] nxt_wl = 2'd0, cur_wl = 2'd0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [23:0] act,
                     input logic [23:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] exp_lj(input int len, input logic [63:0] d);
    logic [23:0] r;
    r = '0;
    for (int i = 0; i < 24; i++)
      if (i < len) r[23-i] = d[len-1-i];
    return r;
  endfunction

  function automatic logic [23:0] exp_rj(input logic [1:0] wl, input logic [63:0] d);
    int n;
    logic signed [31:0] t;
    n = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 18 : (wl == 2'd2) ? 20 : 24;
    t = $signed(d[31:0] << (32 - n)) >>> (32 - n);
    return t[23:0];
  endfunction

  task automatic sck_cycle(input logic ws, input logic b);
    frame_clk = ws;
    ser_data  = b;
    repeat (6) @(negedge clk);
    bit_clk = 1'b1;
    repeat (6) @(negedge clk);
    bit_clk = 1'b0;
  endtask

  task automatic send_half(input logic ws, input int len, input logic [63:0] d);
    for (int i = len - 1; i >= 0; i--) begin
      sck_cycle(ws, d[i]);
      if (i == len - 1 && pend_mode) begin
        fmt_rj    = nxt_rj;
        wlen_sel  = nxt_wl;
        pend_mode = 1'b0;
      end
    end
  endtask

  task automatic set_mode(input logic rj, input logic [1:0] wl);
    nxt_rj = rj; nxt_wl = wl; pend_mode = 1'b1;
    cur_rj = rj; cur_wl = wl;
  endtask

  task automatic send_frame(input int ll, input logic [63:0] dl,
                            input int lr, input logic [63:0] dr);
    exp_t e;
    e.err = cur_rj && (ll < 32 || lr < 32);
    e.l   = cur_rj ? exp_rj(cur_wl, dl) : exp_lj(ll, dl);
    e.r   = cur_rj ? exp_rj(cur_wl, dr) : exp_lj(lr, dr);
    exp_q.push_back(e);
    send_half(1'b1, ll, dl);
    send_half(1'b0, lr, dr);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // monitor / scoreboard
  logic [23:0] last_l = '0, last_r = '0, prev_l = '0, prev_r = '0;
  logic        prev_valid = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !finished) begin
      if (prev_valid)
        chk(!sample_valid, "R6 strobe width", {23'b0, sample_valid}, 24'd0);
      if (sample_valid || frame_err) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected result", left_sample, 24'd0);
        end else begin
          e = exp_q.pop_front();
          chk(frame_err == e.err, "R7 error flag", {23'b0, frame_err}, {23'b0, e.err});
          chk(prev_l == last_l && prev_r == last_r, "R6 hold between frames", prev_l, last_l);
          if (e.err) begin
            chk(left_sample == last_l, "R7 left kept", left_sample, last_l);
            chk(right_sample == last_r, "R7 right kept", right_sample, last_r);
          end else begin
            chk(left_sample == e.l, "R8 R2 R3 R4 R5 left", left_sample, e.l);
            chk(right_sample == e.r, "R8 R2 R3 R4 R5 right", right_sample, e.r);
            last_l = e.l;
            last_r = e.r;
          end
        end
      end
      prev_l     = left_sample;
      prev_r     = right_sample;
      prev_valid = sample_valid;
    end
  end

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(left_sample == 24'd0 && right_sample == 24'd0, "R1 outputs in reset", left_sample, 24'd0);
    chk(!sample_valid && !frame_err, "R1 strobes in reset", {22'b0, sample_valid, frame_err}, 24'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(left_sample == 24'd0 && right_sample == 24'd0 && !sample_valid,
        "R1 idle after reset", right_sample, 24'd0);
    send_half(1'b0, 32, rnd64());   // lead-in right half, no frame

    // left-justified: R2, R3
    send_frame(32, rnd64(), 32, rnd64());
    send_frame(24, {40'd0, 24'h800001}, 24, {40'd0, 24'h7FFFFE});
    send_frame(16, {48'd0, 16'hBEEF}, 20, {44'd0, 20'hFACE7});
    send_frame(40, rnd64(), 9, rnd64());

    // right-justified, 24-bit: R4, R5
    set_mode(1'b1, 2'd3);
    send_frame(32, rnd64(), 32, {32'd0, 32'hFF7FFFFF});
    send_frame(32, {32'd0, 32'h00800000}, 32, rnd64());
    // 16-bit with junk ahead of word
    set_mode(1'b1, 2'd0);
    send_frame(32, {32'd0, 32'hFFFF8123}, 32, {32'd0, 32'hFFFF7FFF});
    send_frame(32, rnd64(), 32, rnd64());
    // 18-bit
    set_mode(1'b1, 2'd1);
    send_frame(32, {32'd0, 32'h0002ABCD}, 32, {32'd0, 32'hFFFD5432});
    // 20-bit with short slots: R7
    set_mode(1'b1, 2'd2);
    send_frame(32, rnd64(), 32, rnd64());
    send_frame(20, rnd64(), 32, rnd64());
    send_frame(32, rnd64(), 24, rnd64());
    send_frame(32, rnd64(), 32, rnd64());

    send_half(1'b1, 32, rnd64());   // closes the last frame
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every frame delivered", 24'(exp_q.size()), 24'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule